// File: doc/BRIEF.md
# Exhaustive Key Search Controller

This block drives a brute-force search for a secret key. After a start pulse it enumerates candidate keys in ascending order from zero. It hands one key per clock to an external pipelined cipher core whose latency is fixed and given by a parameter. The ciphertext produced for every key comes back through a separate input and is compared with a target ciphertext captured at start.

Each issued key travels through an internal alignment line that is exactly as deep as the core. A result is therefore credited to the key that produced it, even though a fresh key enters the core on every cycle. On the first equal result the search halts and the matching key is reported with `found` and `done` high. If every key has been tried with no hit, `done` rises with `found` low.

A parameter selects how keys are aligned with results. One option is a full shift register of keys. The other is a counter that reconstructs each key from the count of results consumed.

Top module: `ks_search_ctrl`

## Requirements
- R1: While reset is high and in the first cycle after it, `done`, `found`, `core_key` and `found_key` are all zero.
- R2: In the cycle after `start` is sampled high, `core_key` is the all-zero key.
- R3: While the search runs, `core_key` rises by exactly one on every clock, with no repeated or skipped value.
- R4: `target_ct` is captured on the clock that samples `start`. Changes to it during a search have no effect on which key is reported.
- R5: Suppose key k is on `core_key` in the cycle after edge E(start)+k, and its ciphertext returns LATENCY cycles later and equals the target. Then `found` and `done` go high after edge E(start)+k+LATENCY+1, and `found_key` equals k.
- R6: A `core_ct` equal to the target during the first LATENCY cycles after start is ignored, because no issued key has reached the comparison yet.
- R7: If no key of the 2^KEY_W keys matches, `done` goes high with `found` low after edge E(start)+2^KEY_W+LATENCY, and `found_key` stays zero.
- R8: The all-ones key is a valid candidate. A match on it reports `found` high and `found_key` all ones.
- R9: Once `done` is high, `done`, `found`, `found_key` and `core_key` hold their values until the next `start`.
- R10: A `start` during a search restarts it from key zero. Results of keys issued before the restart are never credited.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| start | input | 1 | Begins (or restarts) a search and captures the target |
| target_ct | input | CT_W | Ciphertext being searched for |
| core_key | output | KEY_W | Candidate key fed to the cipher core |
| core_ct | input | CT_W | Cipher core result, LATENCY cycles after its key |
| found | output | 1 | A matching key was found |
| done | output | 1 | Search finished, with or without a match |
| found_key | output | KEY_W | The matching key, valid when found is high |

## Verification
The bench forces `core_ct` to equal the target during pipeline fill. A design that compares before its valid chain fills would halt early with a bogus key. It also injects the target into exactly one mid-search cycle and checks that the credited key is the one aligned to that slot. An off-by-one alignment line would report a neighbour key or the wrong timing. A restart is issued while a key whose result would match is still in flight; a design that forgets to clear its valid chain would credit that stale result. The all-ones key is tested both as a hit and as the exhausted case, along with a target change mid-search, so wrap handling that is off by one or a target that is not latched shows up as a wrong key or a wrong cycle.

// File: rtl/ks_pkg.sv
package ks_pkg;
   typedef enum logic [1:0] {
      KS_IDLE  = 2'd0,
      KS_RUN   = 2'd1,
      KS_DRAIN = 2'd2,
      KS_HALT  = 2'd3
   } ks_state_e;

   localparam int KS_ALIGN_SHIFT = 0;
   localparam int KS_ALIGN_COUNT = 1;
endpackage

// File: rtl/ks_key_counter.sv
module ks_key_counter #(
   parameter int KEY_W = 128
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clear,
   input  logic             advance,
   output logic [KEY_W-1:0] key,
   output logic             at_last
);
   initial begin
      assert (KEY_W >= 2) else $error("ks_key_counter: KEY_W must be at least 2");
   end

   logic [KEY_W-1:0] key_q;

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         key_q <= '0;
      end else if (advance) begin
         key_q <= key_q + KEY_W'(1);
      end
   end

   assign key     = key_q;
   assign at_last = &key_q;
endmodule

// File: rtl/ks_align_line.sv
module ks_align_line #(
   parameter int KEY_W      = 128,
   parameter int LATENCY    = 8,
   parameter int ALIGN_MODE = ks_pkg::KS_ALIGN_SHIFT
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clear,
   input  logic             in_valid,
   input  logic             in_last,
   input  logic [KEY_W-1:0] in_key,
   output logic             tail_valid,
   output logic             tail_last,
   output logic [KEY_W-1:0] tail_key
);
   initial begin
      assert (LATENCY >= 1) else $error("ks_align_line: LATENCY must be at least 1");
      assert (ALIGN_MODE == ks_pkg::KS_ALIGN_SHIFT || ALIGN_MODE == ks_pkg::KS_ALIGN_COUNT)
         else $error("ks_align_line: unknown ALIGN_MODE");
   end

   logic [LATENCY-1:0] vld_q;
   logic [LATENCY-1:0] lst_q;

   always_ff @(posedge clk) begin
      if (rst || clear) begin
         vld_q <= '0;
         lst_q <= '0;
      end else begin
         vld_q[0] <= in_valid;
         lst_q[0] <= in_last;
         for (int i = 1; i < LATENCY; i++) begin
            vld_q[i] <= vld_q[i-1];
            lst_q[i] <= lst_q[i-1];
         end
      end
   end

   assign tail_valid = vld_q[LATENCY-1];
   assign tail_last  = lst_q[LATENCY-1];

   generate
      if (ALIGN_MODE == ks_pkg::KS_ALIGN_SHIFT) begin : g_shift
         logic [KEY_W-1:0] key_q [LATENCY];
         always_ff @(posedge clk) begin
            key_q[0] <= in_key;
            for (int i = 1; i < LATENCY; i++) begin
               key_q[i] <= key_q[i-1];
            end
         end
         assign tail_key = key_q[LATENCY-1];
      end else begin : g_count
         logic [KEY_W-1:0] seq_q;
         always_ff @(posedge clk) begin
            if (rst || clear) begin
               seq_q <= '0;
            end else if (vld_q[LATENCY-1]) begin
               seq_q <= seq_q + KEY_W'(1);
            end
         end
         assign tail_key = seq_q;
      end
   endgenerate
endmodule

// File: rtl/ks_match_unit.sv
module ks_match_unit #(
   parameter int KEY_W = 128,
   parameter int CT_W  = 64
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [CT_W-1:0]  target_ct,
   input  logic [CT_W-1:0]  core_ct,
   input  logic             tail_valid,
   input  logic             tail_last,
   input  logic [KEY_W-1:0] tail_key,
   output logic             found,
   output logic             done,
   output logic [KEY_W-1:0] found_key,
   output logic             finish
);
   initial begin
      assert (CT_W >= 1) else $error("ks_match_unit: CT_W must be at least 1");
   end

   logic [CT_W-1:0]  target_q;
   logic             found_q;
   logic             done_q;
   logic [KEY_W-1:0] key_q;
   logic             live;
   logic             equal;

   assign live   = tail_valid && !done_q && !start;
   assign equal  = (core_ct == target_q);
   assign finish = live && (equal || tail_last);

   always_ff @(posedge clk) begin
      if (rst) begin
         target_q <= '0;
         found_q  <= 1'b0;
         done_q   <= 1'b0;
         key_q    <= '0;
      end else if (start) begin
         target_q <= target_ct;
         found_q  <= 1'b0;
         done_q   <= 1'b0;
         key_q    <= '0;
      end else if (live) begin
         if (equal) begin
            found_q <= 1'b1;
            done_q  <= 1'b1;
            key_q   <= tail_key;
         end else if (tail_last) begin
            done_q  <= 1'b1;
         end
      end
   end

   assign found     = found_q;
   assign done      = done_q;
   assign found_key = key_q;

   a_r5_key_aligned: assert property (@(posedge clk) disable iff (rst)
      $rose(found) |-> found_key == $past(tail_key));
   a_r6_no_fill_hit: assert property (@(posedge clk) disable iff (rst)
      $rose(found) |-> $past(tail_valid));
   a_r7_exhaust_last: assert property (@(posedge clk) disable iff (rst)
      ($rose(done) && !found) |-> $past(tail_valid && tail_last));
   a_r9_hold: assert property (@(posedge clk) disable iff (rst)
      (done && !start) |=> (done && $stable(found) && $stable(found_key)));
endmodule

// File: rtl/ks_search_ctrl.sv
module ks_search_ctrl #(
   parameter int KEY_W      = 128,
   parameter int CT_W       = 64,
   parameter int LATENCY    = 8,
   parameter int ALIGN_MODE = ks_pkg::KS_ALIGN_SHIFT
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             start,
   input  logic [CT_W-1:0]  target_ct,
   output logic [KEY_W-1:0] core_key,
   input  logic [CT_W-1:0]  core_ct,
   output logic             found,
   output logic             done,
   output logic [KEY_W-1:0] found_key
);
   import ks_pkg::*;

   initial begin
      assert (LATENCY >= 1) else $error("ks_search_ctrl: LATENCY must be at least 1");
      assert (KEY_W >= 2)   else $error("ks_search_ctrl: KEY_W must be at least 2");
   end

   ks_state_e        state_q;
   logic             issue;
   logic             advance;
   logic             at_last;
   logic             finish;
   logic             tail_valid;
   logic             tail_last;
   logic [KEY_W-1:0] tail_key;

   assign issue   = (state_q == KS_RUN);
   assign advance = issue && !at_last && !start;

   always_ff @(posedge clk) begin
      if (rst) begin
         state_q <= KS_IDLE;
      end else if (start) begin
         state_q <= KS_RUN;
      end else begin
         case (state_q)
            KS_RUN: begin
               if (finish)       state_q <= KS_HALT;
               else if (at_last) state_q <= KS_DRAIN;
            end
            KS_DRAIN: begin
               if (finish)       state_q <= KS_HALT;
            end
            default: state_q <= state_q;
         endcase
      end
   end

   ks_key_counter #(.KEY_W(KEY_W)) u_counter (
      .clk     (clk),
      .rst     (rst),
      .clear   (start),
      .advance (advance),
      .key     (core_key),
      .at_last (at_last)
   );

   ks_align_line #(
      .KEY_W      (KEY_W),
      .LATENCY    (LATENCY),
      .ALIGN_MODE (ALIGN_MODE)
   ) u_align (
      .clk        (clk),
      .rst        (rst),
      .clear      (start),
      .in_valid   (issue && !start),
      .in_last    (issue && !start && at_last),
      .in_key     (core_key),
      .tail_valid (tail_valid),
      .tail_last  (tail_last),
      .tail_key   (tail_key)
   );

   ks_match_unit #(.KEY_W(KEY_W), .CT_W(CT_W)) u_match (
      .clk        (clk),
      .rst        (rst),
      .start      (start),
      .target_ct  (target_ct),
      .core_ct    (core_ct),
      .tail_valid (tail_valid),
      .tail_last  (tail_last),
      .tail_key   (tail_key),
      .found      (found),
      .done       (done),
      .found_key  (found_key),
      .finish     (finish)
   );

   a_r2_first_key_zero: assert property (@(posedge clk) disable iff (rst)
      $past(start) |-> core_key == '0);
   a_r3_key_step: assert property (@(posedge clk) disable iff (rst)
      (state_q == KS_RUN && $past(state_q == KS_RUN) && !$past(start))
         |-> core_key == $past(core_key) + KEY_W'(1));
   a_r9_key_frozen: assert property (@(posedge clk) disable iff (rst)
      (done && !start) |=> $stable(core_key));
   a_r10_done_needs_run: assert property (@(posedge clk) disable iff (rst)
      $rose(done) |-> $past(state_q == KS_RUN || state_q == KS_DRAIN));
endmodule

// File: tb/ks_search_ctrl_test.sv
module ks_search_ctrl_test;
   localparam int KEY_W = 10;
   localparam int CT_W  = 16;
   localparam int LAT   = 5;
   localparam int NKEYS = 1 << KEY_W;

   logic             clk = 1'b0;
   logic             rst = 1'b1;
   logic             start = 1'b0;
   logic [CT_W-1:0]  target_ct = '0;
   logic [KEY_W-1:0] core_key;
   logic [CT_W-1:0]  core_ct;
   logic             found, done;
   logic [KEY_W-1:0] found_key;
   logic             inject = 1'b0;
   logic [CT_W-1:0]  pipe [LAT];

   int checks = 0;
   int errors = 0;
   int n;

   always #5 clk = ~clk;

   function automatic logic [CT_W-1:0] cipher(input int k);
      logic [31:0] p;
      p = 32'(k) * 32'd40503;
      return p[CT_W-1:0] ^ 16'h5A5A;
   endfunction

   always_ff @(posedge clk) begin
      pipe[0] <= cipher(int'(core_key));
      for (int i = 1; i < LAT; i++) pipe[i] <= pipe[i-1];
   end
   assign core_ct = inject ? target_ct : pipe[LAT-1];

   ks_search_ctrl #(.KEY_W(KEY_W), .CT_W(CT_W), .LATENCY(LAT)) uut (
      .clk(clk), .rst(rst), .start(start), .target_ct(target_ct),
      .core_key(core_key), .core_ct(core_ct),
      .found(found), .done(done), .found_key(found_key)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input longint act, input longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
      end
   endtask

   task automatic launch(input logic [CT_W-1:0] tgt);
      @(negedge clk);
      target_ct = tgt;
      start = 1'b1;
      @(posedge clk);
      @(negedge clk);
      start = 1'b0;
      n = 0;
   endtask

   task automatic step();
      @(posedge clk);
      n++;
      @(negedge clk);
   endtask

   task automatic wait_done(input int limit);
      while (!done && n < limit) step();
   endtask

   task automatic t_reset();
      repeat (3) @(posedge clk);
      @(negedge clk);
      chk(done == 0 && found == 0, "R1", "flags in reset", {done, found}, 0);
      chk(core_key == 0 && found_key == 0, "R1", "keys in reset", core_key, 0);
      rst = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk(done == 0 && found == 0 && core_key == 0, "R1", "after reset", core_key, 0);
   endtask

   task automatic t_basic_find();
      int k = 23;
      launch(cipher(k));
      chk(core_key == 0, "R2", "first key", core_key, 0);
      for (int i = 1; i <= 4; i++) begin
         step();
         chk(core_key == KEY_W'(n), "R3", "key step", core_key, n);
      end
      wait_done(k + LAT + 20);
      chk(n == k + LAT + 1, "R5", "hit cycle", n, k + LAT + 1);
      chk(found == 1 && found_key == KEY_W'(k), "R5", "hit key", found_key, k);
   endtask

   task automatic t_hold();
      logic [KEY_W-1:0] fk, ck;
      fk = found_key;
      ck = core_key;
      repeat (10) step();
      chk(done == 1 && found == 1, "R9", "flags held", {done, found}, 3);
      chk(found_key == fk, "R9", "found_key held", found_key, fk);
      chk(core_key == ck, "R9", "core_key frozen", core_key, ck);
   endtask

   task automatic t_fill_ignored();
      int k = 5;
      launch(cipher(k));
      inject = 1'b1;
      while (n < LAT - 1) step();
      inject = 1'b0;
      chk(done == 0, "R6", "no hit during fill", done, 0);
      wait_done(k + LAT + 20);
      chk(n == k + LAT + 1 && found_key == KEY_W'(k), "R6", "real hit after fill", found_key, k);
   endtask

   task automatic t_aligned_inject();
      int k = 37;
      launch(cipher(2000));
      while (n < k + LAT) step();
      chk(done == 0, "R5", "no early hit", done, 0);
      inject = 1'b1;
      step();
      inject = 1'b0;
      chk(done == 1 && found == 1, "R5", "injected hit flags", {done, found}, 3);
      chk(found_key == KEY_W'(k), "R5", "injected hit key", found_key, k);
   endtask

   task automatic t_target_latched();
      int k = 9;
      launch(cipher(k));
      step();
      target_ct = cipher(6);
      wait_done(k + LAT + 20);
      chk(found_key == KEY_W'(k) && n == k + LAT + 1, "R4", "latched target key", found_key, k);
   endtask

   task automatic t_restart();
      int k = 18;
      launch(cipher(900));
      while (n < 20) step();
      launch(cipher(k));
      chk(core_key == 0 && done == 0, "R10", "restart from zero", core_key, 0);
      wait_done(k + LAT + 20);
      chk(n == k + LAT + 1, "R10", "restart hit cycle", n, k + LAT + 1);
      chk(found_key == KEY_W'(k), "R10", "restart hit key", found_key, k);
   endtask

   task automatic t_last_key();
      int k = NKEYS - 1;
      launch(cipher(k));
      wait_done(k + LAT + 20);
      chk(found == 1 && done == 1, "R8", "all-ones hit flags", {done, found}, 3);
      chk(found_key == KEY_W'(k) && n == k + LAT + 1, "R8", "all-ones key", found_key, k);
   endtask

   task automatic t_exhaust();
      launch(cipher(2000));
      wait_done(NKEYS + LAT + 20);
      chk(n == NKEYS + LAT, "R7", "exhaust cycle", n, NKEYS + LAT);
      chk(done == 1 && found == 0, "R7", "exhaust flags", {done, found}, 2);
      chk(found_key == 0, "R7", "exhaust key", found_key, 0);
   endtask

   initial begin : watchdog
      repeat (150000) @(posedge clk);
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

   initial begin
      t_reset();
      t_basic_find();
      t_hold();
      t_fill_ignored();
      t_aligned_inject();
      t_target_latched();
      t_restart();
      t_last_key();
      t_exhaust();
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end
endmodule